// File: doc/BRIEF.md
# Noise-Shaped PWM Requantizer

This block turns a wide signed audio sample into an 8-bit duty code for a counter-driven PWM output. It does not simply drop the low bits. The requantization error of each sample is kept in a three-deep history. A small integer error-feedback filter then adds past errors back into the next sample, so the truncation noise moves away from low frequencies. The filter uses only shifts and adds. The noise transfer has a leading tap of unit magnitude. Second-order shaping puts both zeros at DC. Third-order shaping adds one more zero at half the sample rate.

A free-running 8-bit counter sets the carrier, so the block takes one sample every 256 clocks. A one-clock period-start strobe asks the upstream source for the next sample. A sample accepted during one carrier period sets the duty of the following period. A control state machine has three states:

- ST_WAIT: waiting for a sample.
- ST_CALC: shaping and quantizing the sample.
- ST_HOLD: holding the staged code until the counter wraps.

It has three transitions:

- T_ACCEPT (ST_WAIT to ST_CALC): taken on a valid strobe.
- T_SHAPE (ST_CALC to ST_HOLD): taken unconditionally.
- T_COMMIT (ST_HOLD to ST_WAIT): taken on the last count of a period, which also loads the duty register.

Top module: `nsq_requantizer`

## Requirements
- R1: Reset clears the counter, the duty register and the error history. During and right after reset, `duty_code` is 0 and `pwm_out` is low. The first sample after reset is quantized as if all past errors were zero.
- R2: The carrier period is 256 clocks. `period_start` is high for exactly one clock per period, in the cycle where the counter is 0. This includes the first cycle after reset.
- R3: Within a period, `pwm_out` is high for the first D cycles and low for the rest, where D is `duty_code`. Code 0 never drives the pin high, and code 255 drives it high for 255 of the 256 cycles.
- R4: `duty_code` changes only in a `period_start` cycle. A sample accepted at counter position 253 or earlier sets the duty of the next period.
- R5: With `mode_sel`=0 (second order), the corrected value is v = x + 2·e1 − e2. The signed code is floor(v / 2^28). The stored error is e = v − code·2^28. Here e1, e2 and e3 are the errors of the last, second-last and third-last processed samples.
- R6: With `mode_sel`=1 (third order), the corrected value is v = x + e1 + e2 − e3. The code and the stored error are formed as in R5.
- R7: The corrected value is held in a 40-bit two's-complement accumulator. A value above 2^35−1 gives signed code +127, and a value below −2^35 gives signed code −128. In both cases the stored error is v minus the clamped code times 2^28.
- R8: `duty_code` is the signed code plus 128 (offset binary). Signed code 0 gives 128, and −1 gives 127.
- R9: Only the first `in_valid` of a period is accepted. Further strobes in the same period are ignored and do not change any duty code.
- R10: If no sample arrives during a period, the duty code repeats in the next period. The error history also stays unchanged.
- R11: `mode_sel` is captured together with each sample. Both modes share one error history, so changing mode keeps the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| in_sample | input | 36 | Signed input sample; the top 8 bits are the integer code |
| in_valid | input | 1 | One-clock strobe qualifying `in_sample` |
| mode_sel | input | 1 | 0 = second-order shaping, 1 = third-order shaping |
| pwm_out | output | 1 | PWM output pin |
| duty_code | output | 8 | Duty code of the current period (offset binary) |
| period_start | output | 1 | High in the first cycle of each carrier period |

## Verification
The bench keeps its own 40-bit model of the error history. It predicts every period's duty through long runs of second-order, third-order and mode-switching samples that carry fractional parts. A wrong tap weight, a wrong tap order or a history cleared on a mode change would show up as a wrong code within a few periods.

The bench also covers overload at both rails. A design that saturated the stored error instead of keeping the true residue would give different codes over the following periods.

Other cases covered:
- Extra strobes and silent periods: a design that accepted a second sample, or shifted the history without a sample, would commit the wrong code.
- A sample arriving late in the period: a design that committed mid-period would show a duty change outside the period start.
- Codes 0 and 255: a design with an off-by-one comparator would show a wrong high-time.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } shp_state_e;

    typedef enum logic {
        SHAPE_2ND = 1'b0,
        SHAPE_3RD = 1'b1
    } shape_mode_e;

endpackage

// File: rtl/nsq_err_filter.sv
module nsq_err_filter #(
    parameter int ACC_W = 40
) (
    input  nsq_pkg::shape_mode_e     mode,
    input  logic signed [ACC_W-1:0]  err_d1,
    input  logic signed [ACC_W-1:0]  err_d2,
    input  logic signed [ACC_W-1:0]  err_d3,
    output logic signed [ACC_W-1:0]  feedback
);
    import nsq_pkg::*;

    logic signed [ACC_W-1:0] fb_dc2;
    logic signed [ACC_W-1:0] fb_dc2_nyq;

    // double zero at DC: weights +2, -1
    assign fb_dc2     = (err_d1 <<< 1) - err_d2;
    // extra zero at half rate: weights +1, +1, -1
    assign fb_dc2_nyq = err_d1 + err_d2 - err_d3;

    always_comb begin
        unique case (mode)
            SHAPE_2ND: feedback = fb_dc2;
            SHAPE_3RD: feedback = fb_dc2_nyq;
            default:   feedback = fb_dc2;
        endcase
    end

endmodule

// File: rtl/nsq_quantizer.sv
module nsq_quantizer #(
    parameter int DATA_W  = 36,
    parameter int PWM_W   = 8,
    parameter int GUARD_W = 4
) (
    input  logic signed [DATA_W+GUARD_W-1:0] corrected,
    output logic        [PWM_W-1:0]          duty_off,
    output logic signed [DATA_W+GUARD_W-1:0] residue
);
    localparam int ACC_W  = DATA_W + GUARD_W;
    localparam int FRAC_W = DATA_W - PWM_W;

    localparam logic signed [ACC_W-1:0] HI_LIM =
        {{(GUARD_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO_LIM = ~HI_LIM;

    localparam logic [PWM_W-1:0] CODE_MAX = {1'b0, {(PWM_W-1){1'b1}}};
    localparam logic [PWM_W-1:0] CODE_MIN = {1'b1, {(PWM_W-1){1'b0}}};

    logic              over_hi;
    logic              under_lo;
    logic [PWM_W-1:0]  scode;
    logic signed [ACC_W-1:0] trunc_val;

    assign over_hi  = corrected > HI_LIM;
    assign under_lo = corrected < LO_LIM;

    always_comb begin
        if (over_hi) begin
            scode = CODE_MAX;
        end else if (under_lo) begin
            scode = CODE_MIN;
        end else begin
            scode = corrected[DATA_W-1:FRAC_W];
        end
    end

    assign trunc_val = {{GUARD_W{scode[PWM_W-1]}}, scode, {FRAC_W{1'b0}}};
    assign residue   = corrected - trunc_val;
    assign duty_off  = {~scode[PWM_W-1], scode[PWM_W-2:0]};

endmodule

// File: rtl/nsq_pwm_gen.sv
module nsq_pwm_gen #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [PWM_W-1:0] load_code,
    output logic             period_start,
    output logic             period_end,
    output logic             pwm,
    output logic [PWM_W-1:0] duty
);
    localparam logic [PWM_W-1:0] CNT_LAST = {PWM_W{1'b1}};

    logic [PWM_W-1:0] carrier_cnt;
    logic [PWM_W-1:0] duty_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            carrier_cnt <= '0;
        end else begin
            carrier_cnt <= carrier_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            duty_q <= '0;
        end else if (load_en && period_end) begin
            duty_q <= load_code;
        end
    end

    assign period_start = (carrier_cnt == '0);
    assign period_end   = (carrier_cnt == CNT_LAST);
    assign pwm          = (carrier_cnt < duty_q);
    assign duty         = duty_q;

endmodule

// File: rtl/nsq_shaper_ctrl.sv
module nsq_shaper_ctrl #(
    parameter int DATA_W  = 36,
    parameter int PWM_W   = 8,
    parameter int GUARD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     mode_sel,
    input  logic                     period_end,
    output logic                     commit,
    output logic [PWM_W-1:0]         staged_code
);
    import nsq_pkg::*;

    localparam int ACC_W = DATA_W + GUARD_W;

    shp_state_e state_q;
    shp_state_e state_d;

    logic capture_en;
    logic calc_en;

    logic signed [DATA_W-1:0] sample_q;
    shape_mode_e              mode_q;
    logic signed [ACC_W-1:0]  err_d1;
    logic signed [ACC_W-1:0]  err_d2;
    logic signed [ACC_W-1:0]  err_d3;
    logic [PWM_W-1:0]         staged_q;

    logic signed [ACC_W-1:0]  feedback;
    logic signed [ACC_W-1:0]  corrected;
    logic signed [ACC_W-1:0]  residue;
    logic [PWM_W-1:0]         duty_off;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        capture_en = 1'b0;
        calc_en    = 1'b0;
        commit     = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (in_valid) begin          // T_ACCEPT
                    capture_en = 1'b1;
                    state_d    = ST_CALC;
                end
            end
            ST_CALC: begin                   // T_SHAPE
                calc_en = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (period_end) begin        // T_COMMIT
                    commit  = 1'b1;
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    nsq_err_filter #(.ACC_W(ACC_W)) filt_i (
        .mode     (mode_q),
        .err_d1   (err_d1),
        .err_d2   (err_d2),
        .err_d3   (err_d3),
        .feedback (feedback)
    );

    assign corrected = {{GUARD_W{sample_q[DATA_W-1]}}, sample_q} + feedback;

    nsq_quantizer #(
        .DATA_W  (DATA_W),
        .PWM_W   (PWM_W),
        .GUARD_W (GUARD_W)
    ) quant_i (
        .corrected (corrected),
        .duty_off  (duty_off),
        .residue   (residue)
    );

    // datapath registers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sample_q <= '0;
            mode_q   <= SHAPE_2ND;
            err_d1   <= '0;
            err_d2   <= '0;
            err_d3   <= '0;
            staged_q <= '0;
        end else begin
            if (capture_en) begin
                sample_q <= in_sample;
                mode_q   <= shape_mode_e'(mode_sel);
            end
            if (calc_en) begin
                staged_q <= duty_off;
                err_d1   <= residue;
                err_d2   <= err_d1;
                err_d3   <= err_d2;
            end
        end
    end

    assign staged_code = staged_q;

endmodule

// File: rtl/nsq_requantizer.sv
module nsq_requantizer #(
    parameter int DATA_W  = 36,
    parameter int PWM_W   = 8,
    parameter int GUARD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     in_valid,
    input  logic                     mode_sel,
    output logic                     pwm_out,
    output logic [PWM_W-1:0]         duty_code,
    output logic                     period_start
);
    logic             period_end;
    logic             commit;
    logic [PWM_W-1:0] staged_code;

    nsq_shaper_ctrl #(
        .DATA_W  (DATA_W),
        .PWM_W   (PWM_W),
        .GUARD_W (GUARD_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .mode_sel    (mode_sel),
        .period_end  (period_end),
        .commit      (commit),
        .staged_code (staged_code)
    );

    nsq_pwm_gen #(.PWM_W(PWM_W)) pwm_i (
        .clk          (clk),
        .rst          (rst),
        .load_en      (commit),
        .load_code    (staged_code),
        .period_start (period_start),
        .period_end   (period_end),
        .pwm          (pwm_out),
        .duty         (duty_code)
    );

endmodule

// File: rtl/nsq_requantizer_chk.sv
module nsq_requantizer_chk #(
    parameter int PWM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input logic [PWM_W-1:0] duty_code,
    input logic             period_start
);
    logic [PWM_W-1:0] ref_cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ref_cnt <= '0;
        end else begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            AST_RESET_CLEAR: assert (duty_code == '0 && !pwm_out); // R1
        end
    end

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst) period_start == (ref_cnt == '0)); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) period_start |=> !period_start); // R2
    AST_PWM_ZERO: assert property (@(posedge clk) disable iff (rst) (duty_code == '0) |-> !pwm_out); // R3
    AST_PWM_RISE_AT_START: assert property (@(posedge clk) disable iff (rst) $rose(pwm_out) |-> period_start); // R3
    AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (rst) !$stable(duty_code) |-> period_start); // R4

endmodule

bind nsq_requantizer nsq_requantizer_chk #(.PWM_W(PWM_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pwm_out      (pwm_out),
    .duty_code    (duty_code),
    .period_start (period_start)
);

// File: tb/nsq_requantizer_tb_top.sv
module nsq_requantizer_tb_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [35:0] in_sample = '0;
    logic               in_valid = 1'b0;
    logic               mode_sel = 1'b0;
    logic               pwm_out;
    logic [7:0]         duty_code;
    logic               period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_e1, m_e2, m_e3;
    int     exp_duty;

    always #4 clk = ~clk;

    nsq_requantizer dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_sample    (in_sample),
        .in_valid     (in_valid),
        .mode_sel     (mode_sel),
        .pwm_out      (pwm_out),
        .duty_code    (duty_code),
        .period_start (period_start)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint w40(input longint a);
        return (a <<< 24) >>> 24;
    endfunction

    // R5 R6 R7 R8 model; updates history
    function automatic int model_step(input longint x, input bit mode);
        longint v, code, err;
        if (mode) v = w40(x + m_e1 + m_e2 - m_e3);
        else      v = w40(x + 2 * m_e1 - m_e2);
        if (v > 64'sd34359738367)       code = 127;
        else if (v < -64'sd34359738368) code = -128;
        else                            code = v >>> 28;
        err  = w40(v - (code <<< 28));
        m_e3 = m_e2;
        m_e2 = m_e1;
        m_e1 = err;
        return int'(code + 128);
    endfunction

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(duty_code == 8'd0 && !pwm_out, "R1 reset duty", duty_code, 0);
        rst = 1'b0;
        m_e1 = 0; m_e2 = 0; m_e3 = 0;
        exp_duty = 0;
        chk(period_start == 1'b1, "R2 strobe after reset", period_start, 1);
    endtask

    // starts at negedge of a cycle with counter 0; ends at next such negedge
    task automatic run_period(input bit give, input int at, input longint x,
                              input bit mode, input bit extra, input string tag);
        int hi_cnt = 0;
        int strobe_cnt = 0;
        int bad_pwm = 0;
        int cur = exp_duty;
        chk(duty_code == 8'(cur), {tag, " duty at period start"}, duty_code, cur);
        for (int i = 0; i < 256; i++) begin
            if (i > 0) @(negedge clk);
            if (pwm_out) hi_cnt++;
            if (pwm_out != (i < cur)) bad_pwm++;
            if (period_start) strobe_cnt++;
            if (period_start && i != 0) bad_pwm++;
            if (give && i == at) begin
                in_valid  = 1'b1;
                in_sample = x[35:0];
                mode_sel  = mode;
            end else if (extra && i == at + 10) begin
                in_valid  = 1'b1;
                in_sample = ~x[35:0];
                mode_sel  = ~mode;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(hi_cnt == cur, "R3 high time", hi_cnt, cur);
        chk(bad_pwm == 0, "R3 pwm shape", bad_pwm, 0);
        chk(strobe_cnt == 1 && period_start, "R2 one strobe per period", strobe_cnt, 1);
        if (give) exp_duty = model_step(x, mode);
    endtask

    function automatic longint rnd_in();
        longint r = longint'($urandom_range(200, 0)) - 100;
        longint f = longint'($urandom & 32'h0FFF_FFFF);
        return (r <<< 28) + f;
    endfunction

    initial begin
        void'($urandom(7));
        do_reset();
        run_period(0, 0, 0, 0, 0, "R1");
        // R1 first sample uses empty history; R5 second order sequence
        run_period(1, 0, (64'sd37 <<< 28) + (64'sd1 <<< 26), 0, 0, "R1");
        for (int k = 0; k < 10; k++)
            run_period(1, 0, (64'sd37 <<< 28) + (64'sd1 <<< 26), 0, 0, "R5");
        for (int k = 0; k < 10; k++) run_period(1, 0, rnd_in(), 0, 0, "R5");
        // R6 third order
        for (int k = 0; k < 12; k++) run_period(1, 0, rnd_in(), 1, 0, "R6");
        // R11 alternating modes over shared history
        for (int k = 0; k < 8; k++) run_period(1, 0, rnd_in(), k[0], 0, "R11");
        // R4 late acceptance
        run_period(1, 200, rnd_in(), 0, 0, "R4");
        run_period(1, 120, rnd_in(), 1, 0, "R4");
        run_period(0, 0, 0, 0, 0, "R4");
        // R9 extra strobe ignored
        run_period(1, 3, rnd_in(), 0, 1, "R9");
        run_period(1, 50, rnd_in(), 1, 1, "R9");
        run_period(1, 0, rnd_in(), 0, 0, "R9");
        // R10 silent periods keep duty and history
        run_period(0, 0, 0, 0, 0, "R10");
        run_period(0, 0, 0, 0, 0, "R10");
        run_period(1, 0, rnd_in(), 1, 0, "R10");
        run_period(0, 0, 0, 0, 0, "R10");
        // R8 offset binary from clean history
        do_reset();
        run_period(1, 0, 0, 0, 0, "R8");
        chk(exp_duty == 128, "R8 zero maps to 128", exp_duty, 128);
        run_period(1, 0, -1, 0, 0, "R8");
        chk(exp_duty == 127, "R8 minus one maps to 127", exp_duty, 127);
        run_period(0, 0, 0, 0, 0, "R8");
        // R7 overload at both rails
        do_reset();
        run_period(1, 0, 64'sd34359738367, 0, 0, "R7");
        chk(exp_duty == 255, "R7 top rail code", exp_duty, 255);
        run_period(1, 0, 64'sd34359738367, 0, 0, "R7");
        run_period(1, 0, 64'sd34359738367, 1, 0, "R7");
        for (int k = 0; k < 4; k++) run_period(1, 0, -64'sd34359738368, k[0], 0, "R7");
        run_period(1, 0, 0, 0, 0, "R7");
        run_period(0, 0, 0, 0, 0, "R7");
        do_reset();
        run_period(0, 0, 0, 0, 0, "R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule